// File: doc/BRIEF.md
# RTC Write Guard and Init Controller

This block is the bus-facing control logic of a real-time clock. Registers that change the clock are guarded by an ordered two-byte key. Writes to the guarded registers are dropped unless that key has been presented to the key register. Changing the time or date also needs an init handshake. Software sets an init request. After a fixed number of cycles the block raises init-ready, which halts the calendar core. Only then are time and date writes passed on to the core.

Software reads time, date and sub-second values from shadow copies. A fixed delay after each sub-second tick from the calendar core, the block copies all three live values into the shadows and sets a synchronised flag. Software can clear that flag. A bypass bit sends reads straight to the live counters. In shadow mode, reading the sub-second value freezes all shadows until the date register is read, so one time, sub-second and date triple always comes from a single refresh.

The register port is a plain single-cycle strobe interface. `bus_wr` is accepted on every cycle and is never back-pressured. A `bus_rd` is answered exactly one cycle later with `bus_rvalid`. The calendar-core side is plain control: a halt level, and write strobes that carry a copy of the written word.

Top module: `rtc_guard_ctrl`

## Requirements
- R1: Writing 0xCA and then 0x53 (bits 7:0) to the key register (word address 5) opens access to the guarded registers. Any number of non-key accesses may come between the two key writes.
- R2: While access is open, writing 0xFF to the key register closes it. Writing any other value also closes it; if that value is 0xCA it counts as the first step of a new sequence.
- R3: While the sequence waits for its second byte, a value other than 0x53 closes it. The exception is 0xCA, which restarts the sequence, so a following 0x53 opens access.
- R4: While access is closed, writes to the guarded registers are ignored and their contents do not change. The guarded registers are time (address 0), date (1), status (3) and control (4).
- R5: Status bit 7 is the init request. When a write sets it, init-ready (status bit 6, also driven on `cal_halt`) rises exactly INIT_DLY clock edges after the write edge.
- R6: A write to time or date is forwarded only while access is open and init-ready is high. The cycle after the write edge, it produces a one-cycle `cal_time_we` or `cal_date_we` pulse, with the written word on `cal_wdata`. In every other case no pulse is produced.
- R7: Writing status with bit 7 clear drops init-ready and `cal_halt` at that same write edge.
- R8: A `cal_tick` pulse makes the block copy `cal_time`, `cal_date` and `cal_subsec` into the shadows and set the sync flag (status bit 5). The copy happens REFRESH_DLY edges after the tick is sampled. No copy is made while init-ready is high or while the shadows are frozen.
- R9: An accepted status write with bit 5 clear clears the sync flag. With bit 5 set, the flag is left as it is. Bit 6 is read-only.
- R10: With control bit 5 (bypass) set, reads of addresses 0, 1 and 2 return the live inputs rather than the shadows.
- R11: In shadow mode, a read of the sub-second register (address 2) freezes the shadows until the next read of the date register (address 1).
- R12: `bus_rdata` is valid with `bus_rvalid` one cycle after `bus_rd`. The key register and unused addresses read as zero. The sub-second value is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cal_tick | input | 1 | Sub-second tick from the calendar core |
| cal_time | input | DATA_W | Live time value |
| cal_date | input | DATA_W | Live date value |
| cal_subsec | input | SS_W | Live sub-second counter |
| cal_halt | output | 1 | Init-ready; the calendar stops counting while high |
| cal_time_we | output | 1 | Forwarded time write |
| cal_date_we | output | 1 | Forwarded date write |
| cal_wdata | output | DATA_W | Data for a forwarded write |

## Verification
The hardest situation to reach from the ports is a refresh that falls between a sub-second read and the matching date read. The stimulus first reads the sub-second value. It then changes the live inputs and pulses the tick, and only afterwards reads time and date. It expects the old values and an unchanged sync flag, and it expects the next tick to copy the new values. The key sequencer's many paths are covered by random sequences of key bytes, biased towards the two key values and the lock value. After every key byte a probe toggles the bypass bit, and its read-back shows whether access was open, checked against a reference model in the bench.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
  // word addresses of the register port
  localparam int unsigned A_TIME = 0;
  localparam int unsigned A_DATE = 1;
  localparam int unsigned A_SUB  = 2;
  localparam int unsigned A_STAT = 3;
  localparam int unsigned A_CTRL = 4;
  localparam int unsigned A_KEY  = 5;

  // bit positions inside status and control
  localparam int unsigned B_INIT_REQ = 7;
  localparam int unsigned B_INIT_RDY = 6;
  localparam int unsigned B_SYNC     = 5;
  localparam int unsigned B_BYPASS   = 5;

  // key bytes
  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;
  localparam logic [7:0] KEY_CLOSE  = 8'hFF;

  typedef enum logic [1:0] {
    KS_CLOSED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;
endpackage

// File: rtl/rgc_key_fsm.sv
module rgc_key_fsm
  import rtc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  output logic       unlocked
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we) begin
      unique case (state_q)
        KS_CLOSED: state_d = (key_data == KEY_FIRST) ? KS_HALF : KS_CLOSED;
        KS_HALF: begin
          if (key_data == KEY_SECOND)     state_d = KS_OPEN;
          else if (key_data == KEY_FIRST) state_d = KS_HALF;
          else                            state_d = KS_CLOSED;
        end
        KS_OPEN:  state_d = (key_data == KEY_FIRST) ? KS_HALF : KS_CLOSED;
        default:  state_d = KS_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_CLOSED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);

  // R1: second key after first opens access
  a_r1_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && key_we && key_data == KEY_SECOND) |=> unlocked);

  // R2: close byte always leaves access closed
  a_r2_close_byte_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_data == KEY_CLOSE) |=> !unlocked);

  // R3: access can only open from the half state
  a_r3_open_needs_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(state_q == KS_HALF && key_we));
endmodule

// File: rtl/rgc_init_ctrl.sv
module rgc_init_ctrl #(
  parameter int unsigned INIT_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_we,
  input  logic req_val,
  output logic init_req,
  output logic init_ready
);
  localparam int unsigned CNT_W = (INIT_DLY < 2) ? 1 : $clog2(INIT_DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_DLY - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req   <= 1'b0;
      init_ready <= 1'b0;
      cnt_q      <= '0;
    end else if (req_we) begin
      init_req <= req_val;
      if (!req_val) begin
        init_ready <= 1'b0;
        cnt_q      <= '0;
      end
    end else if (init_req && !init_ready) begin
      if (cnt_q == CNT_LAST) init_ready <= 1'b1;
      else                   cnt_q      <= cnt_q + 1'b1;
    end
  end

  // R5: ready never stands without a request
  a_r5_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |-> init_req);

  // R7: dropping the request drops ready at the same edge
  a_r7_ready_falls_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_req) |-> !init_ready);
endmodule

// File: rtl/rgc_shadow.sv
module rgc_shadow #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SS_W        = 16,
  parameter int unsigned REFRESH_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] live_time,
  input  logic [DATA_W-1:0] live_date,
  input  logic [SS_W-1:0]   live_ss,
  input  logic              halt,
  input  logic              hold_set,
  input  logic              hold_clr,
  input  logic              sync_clr,
  output logic [DATA_W-1:0] shd_time,
  output logic [DATA_W-1:0] shd_date,
  output logic [SS_W-1:0]   shd_ss,
  output logic              sync_flag
);
  logic [REFRESH_DLY-1:0] dly_q;
  logic hold_q;
  logic refresh;

  genvar g;
  generate
    for (g = 0; g < REFRESH_DLY; g++) begin : g_dly
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) dly_q[0] <= 1'b0;
          else        dly_q[0] <= tick;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) dly_q[g] <= 1'b0;
          else        dly_q[g] <= dly_q[g-1];
        end
      end
    end
  endgenerate

  assign refresh = dly_q[REFRESH_DLY-1] && !halt && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_clr) begin
      hold_q <= 1'b0;
    end else if (hold_set) begin
      hold_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_time  <= '0;
      shd_date  <= '0;
      shd_ss    <= '0;
      sync_flag <= 1'b0;
    end else begin
      if (refresh) begin
        shd_time  <= live_time;
        shd_date  <= live_date;
        shd_ss    <= live_ss;
        sync_flag <= 1'b1;
      end else if (sync_clr) begin
        sync_flag <= 1'b0;
      end
    end
  end

  // R11: frozen shadows stay put
  a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ($stable(shd_time) && $stable(shd_date) && $stable(shd_ss)));

  // R8: no refresh while the calendar is halted
  a_r8_no_refresh_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(shd_ss) && $stable(shd_time)));

  // R8: a changed shadow always comes with the sync flag
  a_r8_change_sets_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shd_date) |-> sync_flag);
endmodule

// File: rtl/rtc_guard_ctrl.sv
module rtc_guard_ctrl
  import rtc_guard_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SS_W        = 16,
  parameter int unsigned INIT_DLY    = 4,
  parameter int unsigned REFRESH_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              cal_tick,
  input  logic [DATA_W-1:0] cal_time,
  input  logic [DATA_W-1:0] cal_date,
  input  logic [SS_W-1:0]   cal_subsec,
  output logic              cal_halt,
  output logic              cal_time_we,
  output logic              cal_date_we,
  output logic [DATA_W-1:0] cal_wdata
);
  localparam int unsigned SS_PAD = DATA_W - SS_W;

  logic unlocked, init_req, init_ready, sync_flag, bypass_q;
  logic hit_time, hit_date, hit_sub, hit_stat, hit_ctrl, hit_key;
  logic stat_we, ctrl_we, time_ok, date_ok;
  logic [DATA_W-1:0] shd_time, shd_date;
  logic [SS_W-1:0]   shd_ss;
  logic [DATA_W-1:0] rd_mux;

  assign hit_time = (bus_addr == ADDR_W'(A_TIME));
  assign hit_date = (bus_addr == ADDR_W'(A_DATE));
  assign hit_sub  = (bus_addr == ADDR_W'(A_SUB));
  assign hit_stat = (bus_addr == ADDR_W'(A_STAT));
  assign hit_ctrl = (bus_addr == ADDR_W'(A_CTRL));
  assign hit_key  = (bus_addr == ADDR_W'(A_KEY));

  assign stat_we = bus_wr && hit_stat && unlocked;
  assign ctrl_we = bus_wr && hit_ctrl && unlocked;
  assign time_ok = bus_wr && hit_time && unlocked && init_ready;
  assign date_ok = bus_wr && hit_date && unlocked && init_ready;

  rgc_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (bus_wr && hit_key),
    .key_data (bus_wdata[7:0]),
    .unlocked (unlocked)
  );

  rgc_init_ctrl #(.INIT_DLY(INIT_DLY)) u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_we     (stat_we),
    .req_val    (bus_wdata[B_INIT_REQ]),
    .init_req   (init_req),
    .init_ready (init_ready)
  );

  rgc_shadow #(
    .DATA_W      (DATA_W),
    .SS_W        (SS_W),
    .REFRESH_DLY (REFRESH_DLY)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cal_tick),
    .live_time (cal_time),
    .live_date (cal_date),
    .live_ss   (cal_subsec),
    .halt      (init_ready),
    .hold_set  (bus_rd && hit_sub && !bypass_q),
    .hold_clr  (bus_rd && hit_date),
    .sync_clr  (stat_we && !bus_wdata[B_SYNC]),
    .shd_time  (shd_time),
    .shd_date  (shd_date),
    .shd_ss    (shd_ss),
    .sync_flag (sync_flag)
  );

  assign cal_halt = init_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bypass_q <= 1'b0;
    else if (ctrl_we) bypass_q <= bus_wdata[B_BYPASS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_time_we <= 1'b0;
      cal_date_we <= 1'b0;
      cal_wdata   <= '0;
    end else begin
      cal_time_we <= time_ok;
      cal_date_we <= date_ok;
      if (time_ok || date_ok) cal_wdata <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_time)      rd_mux = bypass_q ? cal_time : shd_time;
    else if (hit_date) rd_mux = bypass_q ? cal_date : shd_date;
    else if (hit_sub)  rd_mux = {{SS_PAD{1'b0}}, (bypass_q ? cal_subsec : shd_ss)};
    else if (hit_stat) begin
      rd_mux[B_INIT_REQ] = init_req;
      rd_mux[B_INIT_RDY] = init_ready;
      rd_mux[B_SYNC]     = sync_flag;
    end else if (hit_ctrl) begin
      rd_mux[B_BYPASS] = bypass_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R6: forwarded writes only under open access and init-ready
  a_r6_fwd_time_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cal_time_we |-> $past(unlocked && init_ready));
  a_r6_fwd_date_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cal_date_we |-> $past(unlocked && init_ready));

  // R4: control register only changes under open access
  a_r4_ctrl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bypass_q) |-> $past(unlocked));

  // R12: read response one cycle after the strobe
  a_r12_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd) |-> bus_rvalid);
endmodule

// File: tb/sim_rtc_guard_ctrl.sv
module sim_rtc_guard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3, DATA_W = 32, SS_W = 16, INIT_DLY = 4, REFRESH_DLY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, cal_tick = 0, cal_halt, cal_time_we, cal_date_we;
  logic [DATA_W-1:0] cal_time = '0, cal_date = '0, cal_wdata;
  logic [SS_W-1:0] cal_subsec = '0;

  int n_chk = 0, n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_guard_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SS_W(SS_W),
                   .INIT_DLY(INIT_DLY), .REFRESH_DLY(REFRESH_DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cal_tick(cal_tick), .cal_time(cal_time),
    .cal_date(cal_date), .cal_subsec(cal_subsec), .cal_halt(cal_halt),
    .cal_time_we(cal_time_we), .cal_date_we(cal_date_we), .cal_wdata(cal_wdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
    check(bus_rvalid === 1'b1, "R12 rvalid", {31'd0, bus_rvalid}, 32'd1);
  endtask

  task automatic tick_pulse();
    @(negedge clk); cal_tick = 1;
    @(negedge clk); cal_tick = 0;
    repeat (REFRESH_DLY + 1) @(negedge clk);
  endtask

  task automatic open_access();
    wr(5, 32'hCA); wr(5, 32'h53);
  endtask

  // reference model of the key sequencer: 0 closed, 1 half, 2 open
  function automatic int key_next(input int s, input logic [7:0] k);
    if (s == 1) return (k == 8'h53) ? 2 : (k == 8'hCA) ? 1 : 0;
    return (k == 8'hCA) ? 1 : 0;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int ks;
    logic bp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    check(cal_halt === 0 && cal_time_we === 0, "R12 reset outputs", {31'd0, cal_halt}, 0);
    rd(3, v); check(v === 0, "R12 reset status", v, 0);
    rd(5, v); check(v === 0, "R12 key reads zero", v, 0);

    // R4: locked writes ignored
    wr(4, 32'h20); rd(4, v); check(v === 0, "R4 ctrl locked", v, 0);
    wr(3, 32'h80); check(cal_halt === 0, "R4 status locked", {31'd0, cal_halt}, 0);
    wr(0, 32'h1234); check(cal_time_we === 0, "R4/R6 time locked", {31'd0, cal_time_we}, 0);

    // R1 unlock, R2 relock with 0xFF
    open_access(); wr(4, 32'h20); rd(4, v); check(v === 32'h20, "R1 open", v, 32'h20);
    wr(5, 32'hFF); wr(4, 32'h0); rd(4, v); check(v === 32'h20, "R2 close", v, 32'h20);
    // R3: CA CA 53 opens, CA 11 53 does not
    wr(5, 32'hCA); wr(5, 32'hCA); wr(5, 32'h53);
    wr(4, 32'h0); rd(4, v); check(v === 0, "R3 restart", v, 0);
    wr(5, 32'hCA); wr(5, 32'h11); wr(5, 32'h53);
    wr(4, 32'h20); rd(4, v); check(v === 0, "R3 wrong byte", v, 0);

    // random key sequences against the model, probed via bypass toggle
    ks = 0; bp = 0;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] k;
      int r = $urandom_range(0, 3);
      k = (r == 0) ? 8'hCA : (r == 1) ? 8'h53 : (r == 2) ? 8'hFF : 8'($urandom);
      wr(5, {24'd0, k});
      ks = key_next(ks, k);
      wr(4, {26'd0, ~bp, 5'd0});
      if (ks == 2) bp = ~bp;
      rd(4, v);
      check(v === {26'd0, bp, 5'd0}, "R1/R2/R3 random key", v, {26'd0, bp, 5'd0});
    end
    wr(5, 32'hFF);
    open_access(); wr(4, 32'h0);

    // R8: refresh and sync
    cal_time = 32'h0012_3456; cal_date = 32'h0024_0515; cal_subsec = 16'h00AB;
    tick_pulse();
    rd(0, v); check(v === 32'h0012_3456, "R8 shadow time", v, 32'h0012_3456);
    rd(3, v); check(v[5] === 1'b1, "R8 sync set", v, 32'h20);
    // R9: writing 1 keeps, writing 0 clears
    wr(3, 32'h20); rd(3, v); check(v[5] === 1'b1, "R9 keep sync", v, 32'h20);
    wr(3, 32'h00); rd(3, v); check(v[5] === 1'b0, "R9 clear sync", v, 0);

    // R11: subsec read freezes until date read
    rd(2, v); check(v === 32'hAB, "R11/R12 subsec", v, 32'hAB);
    cal_time = 32'h0099_0000; cal_date = 32'h0031_1231; cal_subsec = 16'h0011;
    tick_pulse();
    rd(0, v); check(v === 32'h0012_3456, "R11 time frozen", v, 32'h0012_3456);
    rd(3, v); check(v[5] === 1'b0, "R11 no sync while frozen", v, 0);
    rd(1, v); check(v === 32'h0024_0515, "R11 date frozen", v, 32'h0024_0515);
    tick_pulse();
    rd(1, v); check(v === 32'h0031_1231, "R8 date after release", v, 32'h0031_1231);

    // R10: bypass
    cal_time = 32'h0007_0707;
    wr(4, 32'h20); rd(0, v); check(v === 32'h0007_0707, "R10 bypass time", v, 32'h0007_0707);
    rd(2, v); check(v === 32'h11, "R10 bypass subsec", v, 32'h11);
    wr(4, 32'h0);

    // R6: time write without init is dropped
    wr(0, 32'h5555); check(cal_time_we === 0, "R6 no init", {31'd0, cal_time_we}, 0);

    // R5: exact init-ready latency
    wr(3, 32'h80);
    check(cal_halt === 0, "R5 not yet", {31'd0, cal_halt}, 0);
    repeat (INIT_DLY - 1) @(negedge clk);
    check(cal_halt === 0, "R5 one before", {31'd0, cal_halt}, 0);
    @(negedge clk);
    check(cal_halt === 1, "R5 ready", {31'd0, cal_halt}, 1);
    rd(3, v); check(v[7:5] === 3'b110, "R5/R12 status bits", v, 32'hC0);

    // R8: no refresh in init
    cal_date = 32'h0001_0101; tick_pulse();
    rd(1, v); check(v === 32'h0031_1231, "R8 no refresh in init", v, 32'h0031_1231);

    // R6: forwarded writes
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d = $urandom;
      bit dt = i[0];
      wr(dt ? 1 : 0, d);
      check((dt ? cal_date_we : cal_time_we) === 1 && cal_wdata === d,
            "R6 forward", cal_wdata, d);
      @(negedge clk);
      check(cal_time_we === 0 && cal_date_we === 0, "R6 one-cycle pulse",
            {30'd0, cal_time_we, cal_date_we}, 0);
    end
    // R4 guard still on after relock, even with init-ready
    wr(5, 32'hFF); wr(0, 32'h77);
    check(cal_time_we === 0, "R4 relocked in init", {31'd0, cal_time_we}, 0);

    // R7: leaving init drops ready at the write edge
    open_access(); wr(3, 32'h0);
    check(cal_halt === 0, "R7 ready drops", {31'd0, cal_halt}, 0);
    cal_time = 32'h0000_0042; tick_pulse();
    rd(0, v); check(v === 32'h42, "R7/R8 refresh resumes", v, 32'h42);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule